// File: doc/BRIEF.md
# Oversampled SPI Register-Access Slave

This block lets an SPI master read and write a small bank of 16-bit registers. No SPI line is used as a clock. The local system clock samples SPI clock, chip select and MOSI. Clock and chip select each pass through a synchronizer and an edge detector, which turn their transitions into single-cycle strobes in the system clock domain. The frame logic runs on those strobes. It supports SPI mode 0: data is taken in when the SPI clock rises and driven out when it falls.

Every transaction is one 24-bit frame, sent with the most significant bit first. The first seven bits give the register address. The next bit selects write or read. The last sixteen bits carry the data word. On a read, the block loads the addressed register into its output shifter after the eighth bit. It then shifts that value out during the data bits. On a write, the data word reaches the register only once the whole frame has arrived. The bank holds two writable configuration registers, presented on a parallel output port, and one read-only slot that shows an external status word.

Top module: `spi_oversampled_regslave`

## Requirements
- R1: While `rst_n` is low and after it is released, `cfg_regs[15:0]` (address 0) is 2048, `cfg_regs[31:16]` (address 1) is 26000, `spi_miso` is 0 and `cfg_wr_pulse` is 0.
- R2: A frame has 24 bits, most significant bit first: address bits 6..0, then a flag (1 = write, 0 = read), then data bits 15..0.
- R3: SPI clock and chip select pass through two synchronizer flops and one history flop. MOSI is delayed to match. Frames are received correctly for any SPI clock half-period of 2 or more system clocks, which is a rate of up to one quarter of the system clock.
- R4: In a complete write frame to address 0 or 1, the data word is written to that register after the 24th bit. `cfg_wr_pulse` is high for exactly one system clock for each such write.
- R5: In a read frame, `spi_miso` presents the addressed register, MSB first, over the 16 data bits. Each bit becomes valid within 3 system clocks after the SPI clock falling edge that begins it.
- R6: Address 32 reads `status_in`. Any address other than 0, 1 and 32 reads as zero. A write to any address other than 0 or 1 changes no register and produces no pulse.
- R7: `spi_miso` is 0 while chip select is high and during the 8 address and flag bits of every frame.
- R8: If chip select rises before the 24th bit, no write takes place and the bit counter returns to idle, so the next frame is decoded normally.
- R9: During the data bits of a write frame, `spi_miso` stays 0.
- R10: SPI clock edges after the 24th bit of a frame do not change the frame's result. The written word is the data field of the first 24 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock (mode 0, idles low) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| status_in | input | 16 | Read-only status word at address 32 |
| cfg_regs | output | 32 | Configuration registers: [15:0] is address 0, [31:16] is address 1 |
| cfg_wr_pulse | output | 1 | One-cycle strobe when a configuration register is written |

## Verification
The bench drives frames at the fastest allowed SPI rate and at slower rates. If the synchronizer delays for clock and data were misaligned, bits would shift by one position, and every address or data value would come out doubled or scrambled. A truncated write frame is followed by a normal read. A design that did not discard the partial frame would corrupt the register, or would count the next frame from the wrong bit. Extra clock pulses after the 24th bit are sent to catch a counter that wraps or keeps shifting. Writes to unmapped addresses are used to catch a decoder that aliases the upper address bits onto the configuration registers. MISO is checked during the header bits and during write frames, to catch a design that leaks stale shifter contents.

// File: rtl/spi_regslave_pkg.sv
// Shared types and helpers for the oversampled SPI register slave.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_regslave_pkg;

    // Value of the flag bit that follows the address field.
    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } access_e;

    // Total frame length: address, one flag bit, data word.
    function automatic int frame_len(input int addr_w, input int data_w);
        return addr_w + 1 + data_w;
    endfunction

endpackage

// File: rtl/spi_pin_sampler.sv
// Synchronizes a group of asynchronous pins into the clk domain.
// The low EDGE_W pins also get a history flop and single-cycle
// rise/fall strobes.
// Assumes: each pin stays stable for at least two clk periods
// between transitions, so no edge is lost.
module spi_pin_sampler #(
    parameter int unsigned WIDTH       = 3,
    parameter int unsigned EDGE_W      = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  pins,
    output logic [WIDTH-1:0]  level,
    output logic [EDGE_W-1:0] rise,
    output logic [EDGE_W-1:0] fall
);
    logic [WIDTH-1:0]  stage [SYNC_STAGES];
    logic [EDGE_W-1:0] hist;

    // First synchronizer flop: captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= RST_VAL;
        else        stage[0] <= pins;
    end

    genvar g;
    generate
        for (g = 1; g < SYNC_STAGES; g++) begin : g_sync
            // Further synchronizer flops along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= RST_VAL;
                else        stage[g] <= stage[g-1];
            end
        end
    endgenerate

    assign level = stage[SYNC_STAGES-1];

    // History flop: the previous synchronized level of the edge pins.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= RST_VAL[EDGE_W-1:0];
        else        hist <= level[EDGE_W-1:0];
    end

    assign rise = level[EDGE_W-1:0] & ~hist;
    assign fall = ~level[EDGE_W-1:0] & hist;

endmodule

// File: rtl/spi_frame_engine.sv
// Counts frame bits from the SPI clock strobes, assembles the address,
// flag and data fields, and drives MISO on the falling strobes.
// Assumes: the strobes come from spi_pin_sampler, and MOSI is delayed
// to match them. The SPI clock half-period is at least 2 clk.
module spi_frame_engine
    import spi_regslave_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_lvl,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_rise,
    input  logic              cs_fall,
    input  logic              cs_n_lvl,
    input  logic              mosi_lvl,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              miso
);
    localparam int FRAME_BITS = frame_len(ADDR_W, DATA_W);
    localparam int HDR_BITS   = ADDR_W + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    logic              armed;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-2:0] in_sr;
    logic [ADDR_W-1:0] addr_q;
    access_e           acc_q;
    logic [DATA_W-1:0] out_sr;
    logic              data_phase;

    // Frame sequencing: arming, bit counting, field capture, output shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            bit_cnt    <= '0;
            in_sr      <= '0;
            addr_q     <= '0;
            acc_q      <= ACC_READ;
            out_sr     <= '0;
            data_phase <= 1'b0;
            wr_req     <= 1'b0;
            wr_data    <= '0;
        end else begin
            wr_req <= 1'b0;
            if (cs_rise) begin
                armed      <= 1'b0;
                bit_cnt    <= '0;
                data_phase <= 1'b0;
            end else begin
                if (cs_fall) armed <= 1'b1;
                if (sclk_rise && !cs_n_lvl) begin
                    if (armed) begin
                        armed   <= 1'b0;
                        bit_cnt <= CNT_W'(1);
                        in_sr   <= {in_sr[DATA_W-3:0], mosi_lvl};
                    end else if (bit_cnt != '0 && bit_cnt < CNT_W'(FRAME_BITS)) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        in_sr   <= {in_sr[DATA_W-3:0], mosi_lvl};
                        if (bit_cnt == CNT_W'(HDR_BITS - 1)) begin
                            addr_q <= in_sr[ADDR_W-1:0];
                            acc_q  <= access_e'(mosi_lvl);
                        end
                        if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
                            wr_data <= {in_sr, mosi_lvl};
                            wr_req  <= (acc_q == ACC_WRITE);
                        end
                    end
                end
                if (sclk_fall && !cs_n_lvl) begin
                    if (bit_cnt == CNT_W'(HDR_BITS) && !data_phase) begin
                        data_phase <= 1'b1;
                        out_sr     <= (acc_q == ACC_WRITE) ? '0 : rd_data;
                    end else if (data_phase) begin
                        out_sr <= {out_sr[DATA_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign rd_addr = addr_q;
    assign wr_addr = addr_q;
    assign miso    = (!cs_n_lvl && data_phase) ? out_sr[DATA_W-1] : 1'b0;

    // The bit counter never runs past the frame length.
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_BITS));

    // A write request is raised only when the last frame bit has been counted.
    assert_wr_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (bit_cnt == CNT_W'(FRAME_BITS)));

    // The output shifter moves only while the SPI clock is low (mode 0).
    assert_shift_on_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_sr) |-> !sclk_lvl);

    // MISO stays quiet through the header bits.
    assert_miso_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt < CNT_W'(HDR_BITS)) |-> !miso);

    // A chip-select rise always returns the counter to idle.
    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (bit_cnt == '0));

endmodule

// File: rtl/spi_reg_bank.sv
// Register bank: NUM_CFG writable configuration words at addresses
// 0..NUM_CFG-1 and one read-only status word at STATUS_ADDR.
// Every other address reads as zero.
// Assumes: wr_req is a one-cycle request with wr_addr and wr_data valid.
module spi_reg_bank #(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned NUM_CFG     = 2,
    parameter int unsigned STATUS_ADDR = 32,
    parameter logic [NUM_CFG*DATA_W-1:0] CFG_RST = {16'd26000, 16'd2048}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_req,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    input  logic [DATA_W-1:0]         status_in,
    output logic [NUM_CFG*DATA_W-1:0] cfg_flat,
    output logic                      wr_pulse
);
    logic [DATA_W-1:0] cfg_q [NUM_CFG];

    genvar i;
    generate
        for (i = 0; i < NUM_CFG; i++) begin : g_cfg
            // Configuration word i: updated on a write that matches its address.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cfg_q[i] <= CFG_RST[i*DATA_W +: DATA_W];
                else if (wr_req && wr_addr == ADDR_W'(i))
                    cfg_q[i] <= wr_data;
            end
            assign cfg_flat[i*DATA_W +: DATA_W] = cfg_q[i];
        end
    endgenerate

    // Update strobe: high for the cycle after a write that hit a configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_pulse <= 1'b0;
        else        wr_pulse <= wr_req && (wr_addr < ADDR_W'(NUM_CFG));
    end

    // Read decode: status slot, configuration words, zero elsewhere.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(STATUS_ADDR)) rd_data = status_in;
        for (int k = 0; k < NUM_CFG; k++)
            if (rd_addr == ADDR_W'(k)) rd_data = cfg_q[k];
    end

    // The configuration words change only after a write request.
    assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_req) |-> $stable(cfg_flat));

    // The strobe follows only a write request to a mapped configuration address.
    assert_pulse_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> ($past(wr_req) && ($past(wr_addr) < ADDR_W'(NUM_CFG))));

endmodule

// File: rtl/spi_oversampled_regslave.sv
// Top level: an SPI mode-0 register-access slave. All SPI pins are
// oversampled by clk. Instantiates the pin sampler, the frame engine
// and the register bank.
// Assumes: the SPI clock is at most clk/4, and chip select is held
// high between frames for at least 4 clk.
module spi_oversampled_regslave #(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned NUM_CFG     = 2,
    parameter int unsigned STATUS_ADDR = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [NUM_CFG*DATA_W-1:0] CFG_RST = {16'd26000, 16'd2048}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      spi_sclk,
    input  logic                      spi_cs_n,
    input  logic                      spi_mosi,
    output logic                      spi_miso,
    input  logic [DATA_W-1:0]         status_in,
    output logic [NUM_CFG*DATA_W-1:0] cfg_regs,
    output logic                      cfg_wr_pulse
);
    localparam int PIN_SCLK = 0;
    localparam int PIN_CS   = 1;
    localparam int PIN_MOSI = 2;

    logic [2:0]        pin_lvl;
    logic [1:0]        pin_rise;
    logic [1:0]        pin_fall;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_req;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    spi_pin_sampler #(
        .WIDTH       (3),
        .EDGE_W      (2),
        .SYNC_STAGES (SYNC_STAGES),
        .RST_VAL     (3'b010)
    ) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  ({spi_mosi, spi_cs_n, spi_sclk}),
        .level (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    spi_frame_engine #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_lvl  (pin_lvl[PIN_SCLK]),
        .sclk_rise (pin_rise[PIN_SCLK]),
        .sclk_fall (pin_fall[PIN_SCLK]),
        .cs_rise   (pin_rise[PIN_CS]),
        .cs_fall   (pin_fall[PIN_CS]),
        .cs_n_lvl  (pin_lvl[PIN_CS]),
        .mosi_lvl  (pin_lvl[PIN_MOSI]),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .miso      (spi_miso)
    );

    spi_reg_bank #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .NUM_CFG     (NUM_CFG),
        .STATUS_ADDR (STATUS_ADDR),
        .CFG_RST     (CFG_RST)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .status_in (status_in),
        .cfg_flat  (cfg_regs),
        .wr_pulse  (cfg_wr_pulse)
    );

endmodule

// File: tb/test_spi_oversampled_regslave.sv
`timescale 1ns/1ps
module test_spi_oversampled_regslave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [15:0] status_in = 16'h0000;
    logic [31:0] cfg_regs;
    logic        cfg_wr_pulse;

    int   nchk = 0;
    int   nfail = 0;
    int   pulses = 0;
    bit   done = 1'b0;
    logic [15:0] m_cfg [2];

    always #2.5 clk = ~clk;

    spi_oversampled_regslave i_spi_oversampled_regslave (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sclk     (spi_sclk),
        .spi_cs_n     (spi_cs_n),
        .spi_mosi     (spi_mosi),
        .spi_miso     (spi_miso),
        .status_in    (status_in),
        .cfg_regs     (cfg_regs),
        .cfg_wr_pulse (cfg_wr_pulse)
    );

    // Count configuration write strobes, sampled away from the active edge.
    always @(negedge clk) if (rst_n && cfg_wr_pulse) pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [6:0] a);
        if (a == 7'd0)  return m_cfg[0];
        if (a == 7'd1)  return m_cfg[1];
        if (a == 7'd32) return status_in;
        return 16'h0000;
    endfunction

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Mode-0 master: nbits frame bits, then extra clock pulses, then chip select high.
    // MISO is sampled at the end of each high phase.
    task automatic frame(input logic [6:0] a, input logic w, input logic [15:0] d,
                         input int half, input int nbits, input int extra,
                         output logic [15:0] rdata, output bit hdr_quiet);
        logic [23:0] fr;
        fr = {a, w, d};
        rdata = '0;
        hdr_quiet = 1'b1;
        @(negedge clk);
        spi_cs_n = 1'b0;
        wclk(4);
        for (int b = 0; b < nbits; b++) begin
            spi_sclk = 1'b0;
            spi_mosi = fr[23-b];
            wclk(half);
            spi_sclk = 1'b1;
            wclk(half);
            if (b < 8) begin
                if (spi_miso !== 1'b0) hdr_quiet = 1'b0;
            end else begin
                rdata[23-b] = spi_miso;
            end
        end
        for (int e = 0; e < extra; e++) begin
            spi_sclk = 1'b0;
            wclk(half);
            spi_sclk = 1'b1;
            wclk(half);
        end
        spi_sclk = 1'b0;
        wclk(half);
        spi_cs_n = 1'b1;
        wclk(8);
    endtask

    task automatic rd_check(input string req, input logic [6:0] a, input int half);
        logic [15:0] r;
        logic [15:0] e;
        bit q;
        e = exp_read(a);
        frame(a, 1'b0, 16'h0000, half, 24, 0, r, q);
        chk(req, {16'h0, r}, {16'h0, e});
        chk("R7 header quiet", {31'h0, q}, 32'h1);
    endtask

    task automatic wr_full(input string req, input logic [6:0] a, input logic [15:0] d,
                           input int half, input int extra);
        logic [15:0] r;
        bit q;
        int p0;
        p0 = pulses;
        frame(a, 1'b1, d, half, 24, extra, r, q);
        if (a < 7'd2) m_cfg[a[0]] = d;
        chk({req, " cfg"}, cfg_regs, {m_cfg[1], m_cfg[0]});
        chk({req, " pulses"}, pulses - p0, (a < 7'd2) ? 1 : 0);
        chk("R9 write miso", {16'h0, r}, 32'h0);
        chk("R7 header quiet", {31'h0, q}, 32'h1);
    endtask

    initial begin
        logic [15:0] r;
        bit q;
        int p0;
        void'($urandom(32'h5EED1234));
        m_cfg[0] = 16'd2048;
        m_cfg[1] = 16'd26000;
        wclk(3);
        chk("R1 reset cfg", cfg_regs, {16'd26000, 16'd2048});
        chk("R1 reset miso", {31'h0, spi_miso}, 32'h0);
        rst_n = 1'b1;
        wclk(4);
        chk("R1 cfg after release", cfg_regs, {16'd26000, 16'd2048});
        chk("R1 pulse idle", pulses, 0);
        chk("R7 miso cs high", {31'h0, spi_miso}, 32'h0);

        rd_check("R3 R5 read addr0 quarter rate", 7'd0, 2);
        rd_check("R5 read addr1", 7'd1, 4);
        status_in = 16'hA5C3;
        rd_check("R6 read status", 7'd32, 3);
        rd_check("R6 read unmapped", 7'd5, 2);
        wr_full("R2 R4 write addr0", 7'd0, 16'h1234, 2, 0);
        rd_check("R4 readback addr0", 7'd0, 2);
        wr_full("R6 write unmapped", 7'd77, 16'hFFFF, 2, 0);
        wr_full("R6 write status addr", 7'd32, 16'h5555, 3, 0);
        rd_check("R6 status still input", 7'd32, 2);

        // R8: truncated write frame, then a normal read.
        p0 = pulses;
        frame(7'd1, 1'b1, 16'hDEAD, 2, 20, 0, r, q);
        chk("R8 abort cfg", cfg_regs, {m_cfg[1], m_cfg[0]});
        chk("R8 abort pulses", pulses - p0, 0);
        rd_check("R8 read after abort", 7'd1, 2);

        // R10: extra clocks after the 24th bit.
        wr_full("R10 extra clocks", 7'd1, 16'hBEEF, 2, 3);
        rd_check("R10 readback", 7'd1, 4);
        chk("R7 miso cs high", {31'h0, spi_miso}, 32'h0);

        for (int n = 0; n < 60; n++) begin
            logic [6:0] a;
            int sel;
            int half;
            sel = $urandom % 4;
            a = (sel == 0) ? 7'd0 : (sel == 1) ? 7'd1 : (sel == 2) ? 7'd32 : 7'($urandom);
            half = 2 + ($urandom % 3);
            status_in = 16'($urandom);
            if ($urandom % 2) wr_full("R4 R6 random write", a, 16'($urandom), half, 0);
            else              rd_check("R5 R6 random read", a, half);
        end
        chk("R7 miso idle end", {31'h0, spi_miso}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule